// File: doc/BRIEF.md
# Block-Lock Write Protection Unit

This unit decides whether a write to a serial memory device is allowed. It holds the configuration fields that survive power cycles: the status-lock enable, the two watchdog period bits and the two block-protection bits. They are modelled as registers that return to factory values on reset. The unit also holds two volatile bits: the write-enable latch and a user flag. From these bits, the level of an external write-protect pin and the requested array address, it grants or refuses each array byte write and each status-register write. It also assembles the 8-bit status byte that a serial front end would shift out.

A granted write opens a write cycle. The write-in-progress bit stays set until the nonvolatile cell timer (outside this block) pulses the completion strobe. Configuration values carried by a status write are held pending and take effect only at that completion strobe. The same completion clears the write-enable latch.

Top module: `blk_wprot_unit`

## Requirements
- R1: After reset the status byte reads 0x30. Its layout, from bit 7 down to bit 0, is: lock enable, flag, watchdog bit 1, watchdog bit 0, block bit 1, block bit 0, enable latch, write in progress. Reset leaves the lock enable 0, the watchdog bits 11, the block bits 00, and the flag, latch and busy bits all 0.
- R2: While the enable latch is 0, no array write and no status write is granted.
- R3: With a 12-bit address, the block bits select the protected region. 00 protects no address. 01 protects 0xC00 to 0xFFF. 10 protects 0x800 to 0xFFF. 11 protects every address. A write to a protected address is refused even when the latch is set.
- R4: When the lock enable is 1 and the protect pin is low, status writes are refused. When the lock enable is 0, the pin level does not affect status-write grants.
- R5: A status write takes the lock enable from data bit 7, the watchdog bits from data bits 5:4 and the block bits from data bits 3:2. Data bits 6, 1 and 0 are ignored. The new values appear in the status byte only after the completion strobe.
- R6: If the pin lock becomes active while a granted status write is still pending, that write still commits at completion. Later status writes are refused.
- R7: The latch-set strobe sets the enable latch. The latch-clear strobe clears it and wins if both strobes arrive together. Completion of a granted write also clears the latch.
- R8: The flag-set strobe sets the flag. The flag-clear strobe clears it and wins if both strobes arrive together.
- R9: The write-in-progress bit is 1 from the cycle after a grant until the cycle after the completion strobe. Requests made while it is 1 are refused. A completion strobe while idle changes nothing.
- R10: If an array request and a status request arrive in the same cycle, only the status write can be granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| prot_pin_lvl | input | 1 | Write-protect pin level; low requests the status lock |
| arr_wr_req | input | 1 | Array byte write request |
| arr_addr | input | ADDR_W | Array byte address of the request |
| sts_wr_req | input | 1 | Status-register write request |
| sts_wr_data | input | 8 | Data byte of the status write |
| wel_set | input | 1 | Set strobe for the enable latch |
| wel_clr | input | 1 | Clear strobe for the enable latch |
| flag_set | input | 1 | Set strobe for the flag |
| flag_clr | input | 1 | Clear strobe for the flag |
| wr_done | input | 1 | Completion strobe of the write cycle |
| status_byte | output | 8 | Assembled status byte |
| arr_wr_grant | output | 1 | Array write permitted (same cycle as request) |
| sts_wr_grant | output | 1 | Status write permitted (same cycle as request) |

## Verification
The hardest situation to reach is the pin lock becoming active between a status-write grant and its completion strobe. The pending write must still commit, and the next status write must then be refused. The stimulus grants a write that sets the lock enable, drops the pin while the cycle is still open, and only then pulses completion. It then tries another status write. A table walk covers each block-bit setting at addresses on both sides of its region boundary.

// File: rtl/wlock_pkg.sv
package wlock_pkg;

    typedef struct packed {
        logic       lock_en;
        logic [1:0] wdog;
        logic [1:0] blk;
    } nv_cfg_t;

    localparam nv_cfg_t CFG_FACTORY = '{lock_en: 1'b0, wdog: 2'b11, blk: 2'b00};

    typedef enum logic [1:0] {
        BLK_NONE    = 2'b00,
        BLK_QUARTER = 2'b01,
        BLK_HALF    = 2'b10,
        BLK_ALL     = 2'b11
    } blk_sel_e;

    // Fields a status write may change; bits 6, 1 and 0 of the byte are dropped.
    function automatic nv_cfg_t cfg_from_byte(input logic [7:0] d);
        nv_cfg_t c;
        c.lock_en = d[7];
        c.wdog    = d[5:4];
        c.blk     = d[3:2];
        return c;
    endfunction

    function automatic logic [7:0] pack_status(input nv_cfg_t c, input logic flg,
                                               input logic wel, input logic wip);
        return {c.lock_en, flg, c.wdog, c.blk, wel, wip};
    endfunction

endpackage

// File: rtl/wlock_region_guard.sv
module wlock_region_guard
    import wlock_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [1:0]        blk,
    input  logic [ADDR_W-1:0] addr,
    output logic              locked
);
    localparam logic [ADDR_W:0] SPAN      = (ADDR_W+1)'(1) << ADDR_W;
    localparam logic [ADDR_W:0] HALF_BASE = SPAN >> 1;
    localparam logic [ADDR_W:0] QTR_BASE  = HALF_BASE + (SPAN >> 2);

    logic [ADDR_W:0] addr_x;
    assign addr_x = {1'b0, addr};

    always_comb begin
        unique case (blk_sel_e'(blk))
            BLK_NONE:    locked = 1'b0;
            BLK_QUARTER: locked = (addr_x >= QTR_BASE);
            BLK_HALF:    locked = (addr_x >= HALF_BASE);
            default:     locked = 1'b1;
        endcase
    end

    // R3: the lowest address is never in a quarter or half region
    always_comb begin
        if (addr == '0 && blk != 2'b11)
            p_low_open_r3: assert (!locked);
    end

endmodule

// File: rtl/wlock_volatile.sv
module wlock_volatile (
    input  logic clk,
    input  logic rst,
    input  logic wel_set,
    input  logic wel_clr,
    input  logic cycle_end,
    input  logic flag_set,
    input  logic flag_clr,
    output logic wel,
    output logic flg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wel <= 1'b0;
            flg <= 1'b0;
        end else begin
            if (wel_clr || cycle_end) wel <= 1'b0;
            else if (wel_set)         wel <= 1'b1;
            if (flag_clr)             flg <= 1'b0;
            else if (flag_set)        flg <= 1'b1;
        end
    end

    p_wel_clr_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (wel_clr || cycle_end) |=> !wel);
    p_flag_clr_wins_r8: assert property (@(posedge clk) disable iff (rst)
        flag_clr |=> !flg);
    p_flag_set_r8: assert property (@(posedge clk) disable iff (rst)
        (flag_set && !flag_clr) |=> flg);

endmodule

// File: rtl/wlock_nv_store.sv
module wlock_nv_store
    import wlock_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sts_grant,
    input  logic       arr_grant,
    input  logic [7:0] sts_data,
    input  logic       wr_done,
    output nv_cfg_t    cfg,
    output logic       wip,
    output logic       cycle_end
);
    nv_cfg_t pend_cfg;
    logic    pend_sts;

    assign cycle_end = wr_done && wip;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= CFG_FACTORY;
            pend_cfg <= CFG_FACTORY;
            pend_sts <= 1'b0;
            wip      <= 1'b0;
        end else if (sts_grant) begin
            pend_cfg <= cfg_from_byte(sts_data);
            pend_sts <= 1'b1;
            wip      <= 1'b1;
        end else if (arr_grant) begin
            pend_sts <= 1'b0;
            wip      <= 1'b1;
        end else if (cycle_end) begin
            if (pend_sts) cfg <= pend_cfg;
            pend_sts <= 1'b0;
            wip      <= 1'b0;
        end
    end

    p_cfg_only_at_end_r5: assert property (@(posedge clk) disable iff (rst)
        !cycle_end |=> $stable(cfg));
    p_busy_after_grant_r9: assert property (@(posedge clk) disable iff (rst)
        (sts_grant || arr_grant) |=> wip);
    p_idle_after_end_r9: assert property (@(posedge clk) disable iff (rst)
        cycle_end |=> !wip);

endmodule

// File: rtl/blk_wprot_unit.sv
module blk_wprot_unit
    import wlock_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prot_pin_lvl,
    input  logic              arr_wr_req,
    input  logic [ADDR_W-1:0] arr_addr,
    input  logic              sts_wr_req,
    input  logic [7:0]        sts_wr_data,
    input  logic              wel_set,
    input  logic              wel_clr,
    input  logic              flag_set,
    input  logic              flag_clr,
    input  logic              wr_done,
    output logic [7:0]        status_byte,
    output logic              arr_wr_grant,
    output logic              sts_wr_grant
);
    nv_cfg_t cfg;
    logic    wip, wel, flg, cycle_end, region_locked, sts_locked;

    wlock_region_guard #(.ADDR_W(ADDR_W)) u_guard (
        .blk    (cfg.blk),
        .addr   (arr_addr),
        .locked (region_locked)
    );

    wlock_volatile u_vol (
        .clk       (clk),
        .rst       (rst),
        .wel_set   (wel_set),
        .wel_clr   (wel_clr),
        .cycle_end (cycle_end),
        .flag_set  (flag_set),
        .flag_clr  (flag_clr),
        .wel       (wel),
        .flg       (flg)
    );

    wlock_nv_store u_nv (
        .clk       (clk),
        .rst       (rst),
        .sts_grant (sts_wr_grant),
        .arr_grant (arr_wr_grant),
        .sts_data  (sts_wr_data),
        .wr_done   (wr_done),
        .cfg       (cfg),
        .wip       (wip),
        .cycle_end (cycle_end)
    );

    // Pin lock only counts when the stored lock enable is set.
    assign sts_locked   = cfg.lock_en && !prot_pin_lvl;
    assign sts_wr_grant = sts_wr_req && wel && !wip && !sts_locked;
    assign arr_wr_grant = arr_wr_req && !sts_wr_req && wel && !wip && !region_locked;
    assign status_byte  = pack_status(cfg, flg, wel, wip);

    p_need_latch_r2: assert property (@(posedge clk) disable iff (rst)
        (arr_wr_grant || sts_wr_grant) |-> status_byte[1]);
    p_pin_lock_r4: assert property (@(posedge clk) disable iff (rst)
        (status_byte[7] && !prot_pin_lvl) |-> !sts_wr_grant);
    p_all_blocked_r3: assert property (@(posedge clk) disable iff (rst)
        (status_byte[3:2] == 2'b11) |-> !arr_wr_grant);
    p_one_grant_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({arr_wr_grant, sts_wr_grant}));
    p_busy_refuse_r9: assert property (@(posedge clk) disable iff (rst)
        status_byte[0] |-> !(arr_wr_grant || sts_wr_grant));

endmodule

// File: tb/sim_blk_wprot_unit.sv
module sim_blk_wprot_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prot_pin_lvl = 1'b1;
    logic        arr_wr_req = 1'b0;
    logic [11:0] arr_addr = '0;
    logic        sts_wr_req = 1'b0;
    logic [7:0]  sts_wr_data = '0;
    logic        wel_set = 1'b0, wel_clr = 1'b0;
    logic        flag_set = 1'b0, flag_clr = 1'b0;
    logic        wr_done = 1'b0;
    logic [7:0]  status_byte;
    logic        arr_wr_grant, sts_wr_grant;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    blk_wprot_unit #(.ADDR_W(12)) u0 (
        .clk(clk), .rst(rst), .prot_pin_lvl(prot_pin_lvl),
        .arr_wr_req(arr_wr_req), .arr_addr(arr_addr),
        .sts_wr_req(sts_wr_req), .sts_wr_data(sts_wr_data),
        .wel_set(wel_set), .wel_clr(wel_clr),
        .flag_set(flag_set), .flag_clr(flag_clr), .wr_done(wr_done),
        .status_byte(status_byte), .arr_wr_grant(arr_wr_grant),
        .sts_wr_grant(sts_wr_grant)
    );

    // R3 table: block bits, address, expected grant
    localparam int NV = 12;
    localparam logic [1:0]  V_BLK  [NV] = '{2'd0, 2'd0, 2'd1, 2'd1, 2'd1, 2'd1,
                                            2'd2, 2'd2, 2'd2, 2'd3, 2'd3, 2'd3};
    localparam logic [11:0] V_ADDR [NV] = '{12'h000, 12'hFFF, 12'hBFF, 12'hC00, 12'hFFF, 12'h7FF,
                                            12'h7FF, 12'h800, 12'hBFF, 12'h000, 12'h7FF, 12'hFFF};
    localparam logic        V_EXP  [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1,
                                            1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic sts_write(input logic [7:0] d, input logic exp_g, input string tag);
        wel_set = 1'b1; step(); wel_set = 1'b0;
        sts_wr_req = 1'b1; sts_wr_data = d;
        #1 check(tag, sts_wr_grant, exp_g);
        step();
        sts_wr_req = 1'b0;
        if (exp_g) begin
            wr_done = 1'b1; step(); wr_done = 1'b0;
        end else begin
            wel_clr = 1'b1; step(); wel_clr = 1'b0;
        end
    endtask

    task automatic arr_try(input logic [11:0] a, input logic exp_g, input string tag);
        wel_set = 1'b1; step(); wel_set = 1'b0;
        arr_wr_req = 1'b1; arr_addr = a;
        #1 check(tag, arr_wr_grant, exp_g);
        step();
        arr_wr_req = 1'b0;
        if (exp_g) begin
            wr_done = 1'b1; step(); wr_done = 1'b0;
        end else begin
            wel_clr = 1'b1; step(); wel_clr = 1'b0;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1 check("R1 reset status", status_byte, 8'h30);

        // R2: latch clear, both kinds of request refused
        arr_wr_req = 1'b1; arr_addr = 12'h000;
        #1 check("R2 array without latch", arr_wr_grant, 0);
        arr_wr_req = 1'b0; sts_wr_req = 1'b1;
        #1 check("R2 status without latch", sts_wr_grant, 0);
        sts_wr_req = 1'b0;
        step();

        // R7: set, then set and clear together
        wel_set = 1'b1; step();
        check("R7 latch set", status_byte, 8'h32);
        wel_clr = 1'b1; step(); wel_set = 1'b0; wel_clr = 1'b0;
        check("R7 clear wins", status_byte, 8'h30);

        // R9: busy window of an array write, completion clears latch
        wel_set = 1'b1; step(); wel_set = 1'b0;
        arr_wr_req = 1'b1; arr_addr = 12'h000;
        #1 check("R9 array grant", arr_wr_grant, 1);
        step();
        check("R9 busy status", status_byte, 8'h33);
        #1 check("R9 refused while busy", arr_wr_grant, 0);
        arr_wr_req = 1'b0;
        wr_done = 1'b1; step(); wr_done = 1'b0;
        check("R7 latch cleared by completion", status_byte, 8'h30);
        // R9: completion while idle changes nothing
        wel_set = 1'b1; step(); wel_set = 1'b0;
        wr_done = 1'b1; step(); wr_done = 1'b0;
        check("R9 idle completion ignored", status_byte, 8'h32);
        wel_clr = 1'b1; step(); wel_clr = 1'b0;

        // R5: value held until completion, ignored data bits
        wel_set = 1'b1; step(); wel_set = 1'b0;
        sts_wr_req = 1'b1; sts_wr_data = 8'hFF;
        #1 check("R5 grant", sts_wr_grant, 1);
        step(); sts_wr_req = 1'b0;
        check("R5 not yet applied", status_byte, 8'h33);
        wr_done = 1'b1; step(); wr_done = 1'b0;
        check("R5 applied at completion", status_byte, 8'hBC);
        sts_write(8'h00, 1'b1, "R5 restore grant");
        check("R5 restored", status_byte, 8'h00);

        // R4: lock enable with pin low refuses; pin ignored when disabled
        sts_write(8'h80, 1'b1, "R4 set lock enable");
        prot_pin_lvl = 1'b0;
        sts_write(8'h00, 1'b0, "R4 locked by pin");
        check("R4 config kept", status_byte, 8'h80);
        prot_pin_lvl = 1'b1;
        sts_write(8'h00, 1'b1, "R4 pin high allows");
        prot_pin_lvl = 1'b0;
        sts_write(8'h0C, 1'b1, "R4 pin ignored when disabled");
        check("R4 write landed", status_byte, 8'h0C);
        sts_write(8'h00, 1'b1, "R4 cleanup");

        // R6: lock engages while a status write is pending
        prot_pin_lvl = 1'b1;
        wel_set = 1'b1; step(); wel_set = 1'b0;
        sts_wr_req = 1'b1; sts_wr_data = 8'h80;
        #1 check("R6 grant", sts_wr_grant, 1);
        step(); sts_wr_req = 1'b0;
        prot_pin_lvl = 1'b0;
        step();
        wr_done = 1'b1; step(); wr_done = 1'b0;
        check("R6 pending write committed", status_byte, 8'h80);
        sts_write(8'h00, 1'b0, "R6 later write refused");
        prot_pin_lvl = 1'b1;
        sts_write(8'h00, 1'b1, "R6 cleanup");

        // R8: flag strobes
        flag_set = 1'b1; step(); flag_set = 1'b0;
        check("R8 flag set", status_byte, 8'h40);
        flag_set = 1'b1; flag_clr = 1'b1; step(); flag_set = 1'b0; flag_clr = 1'b0;
        check("R8 clear wins", status_byte, 8'h00);

        // R10: simultaneous requests
        wel_set = 1'b1; step(); wel_set = 1'b0;
        sts_wr_req = 1'b1; sts_wr_data = 8'h00; arr_wr_req = 1'b1; arr_addr = 12'h000;
        #1 check("R10 status granted", sts_wr_grant, 1);
        check("R10 array refused", arr_wr_grant, 0);
        step(); sts_wr_req = 1'b0; arr_wr_req = 1'b0;
        wr_done = 1'b1; step(); wr_done = 1'b0;
        check("R10 idle afterwards", status_byte, 8'h00);

        // R3: region table walk
        for (int i = 0; i < NV; i++) begin
            sts_write({4'b0011, V_BLK[i], 2'b00}, 1'b1, "R3 configure");
            arr_try(V_ADDR[i], V_EXP[i], $sformatf("R3 blk=%0d addr=%0h", V_BLK[i], V_ADDR[i]));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule